// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a bank of 32-bit registers over a four-wire serial link. The link has an active-low select, a clock, host-to-port data and port-to-host data. The three link inputs are resynchronised into the system clock domain. The port detects clock edges there, so the serial clock must run well below the system clock; each serial half-period must last at least four system cycles. Each transaction opens with an 8-bit command and an 8-bit register index. After those come one or more 32-bit words, each sent most significant bit first.

The command chooses two things. It sets the direction of the transfer, and it sets how the register index moves after each word: it rises, falls, or stays put. The index wraps at both ends of its 8-bit range. A write is applied only once all 32 bits of a word have arrived. The port-to-host line is actively driven only while read data is being returned. The register bank has a fixed pattern word that a host can poll to detect when the port responds. It also has a status word whose low bit reports when initialisation has finished. The remaining registers are a small window of read/write scratch registers at the top of the index range.

Top module: `spi_reg_port`

## Requirements
- R1: After select falls, the port takes an 8-bit command, then an 8-bit register index, then 32-bit data words, all most significant bit first. Input is sampled on the rising serial clock edge, and output changes on the falling edge.
- R2: Command codes are 0x0B read-rising, 0x0A read-fixed, 0x09 read-falling, 0x02 write-rising, 0x03 write-fixed and 0x01 write-falling.
- R3: In a rising burst the index increases by one after every word and wraps from 0xFF to 0x00.
- R4: In a falling burst the index decreases by one after every word and wraps from 0x00 to 0xFF. This applies to both reads and writes.
- R5: In a fixed burst every word uses the same index. For a write, the last complete word wins.
- R6: A write is applied only when all 32 bits of a word have been received. A word cut short by select rising is discarded, and earlier complete words of the same burst stay written.
- R7: The output enable `spi_miso_oe` is low while select is high, during the command and index phases, and for the whole of a write transaction.
- R8: While `rst_n` is low the port returns no data: `spi_miso_oe` stays low whatever the link does.
- R9: Index 0x00 reads as the constant 0x1A2B3C4D, and writes to it have no effect.
- R10: Index 0x01 reads as 0 in bits 31..1. Bit 0 (ready) reads 0 until INIT_CYCLES system cycles after reset release, then 1. The register is read-only.
- R11: Indices 0xFC to 0xFF are read/write scratch registers that reset to 0. All other indices read 0 and ignore writes.
- R12: Any other command code is ignored: no register changes, and `spi_miso_oe` stays low until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High when `spi_miso` is actively driven |

## Verification
Writes are first made as rising bursts that cross 0xFF into the read-only pattern register. They are then read back as falling bursts that cross 0x00, so a wrong step direction or a missing wrap shows up as data from the wrong register. Fixed-index bursts use two different words, which separates "last word wins" from "first word wins" and from stepping. Truncated words are sent both alone and after a complete word, to tell a dropped partial word from a lost burst. An unknown command followed by all-ones data, and writes to read-only and unmapped indices, show whether anything leaks into the bank. A read made while reset is held, and an early status read, cover the conditions under which the port does not respond or is not ready.

// File: rtl/spi_reg_pkg.sv
// Package: shared widths, command codes, phase and step types for the
// serial register port. Assumes an 8-bit register index and 32-bit words.
package spi_reg_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 32;
    parameter int CMD_W  = 8;

    localparam logic [DATA_W-1:0] PATTERN_WORD = 32'h1A2B_3C4D;

    typedef enum logic [1:0] {STEP_UP, STEP_DOWN, STEP_HOLD} step_e;
    typedef enum logic [1:0] {PH_CMD, PH_IDX, PH_DATA, PH_SKIP} phase_e;

    typedef struct packed {
        logic  valid;
        logic  rd;
        step_e step;
    } cmd_t;

    // Turn a command byte into direction and index-step mode.
    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] c);
        cmd_t r;
        r = '{valid: 1'b1, rd: 1'b0, step: STEP_HOLD};
        case (c)
            8'h0B: begin r.rd = 1'b1; r.step = STEP_UP;   end
            8'h0A: begin r.rd = 1'b1; r.step = STEP_HOLD; end
            8'h09: begin r.rd = 1'b1; r.step = STEP_DOWN; end
            8'h02: r.step = STEP_UP;
            8'h03: r.step = STEP_HOLD;
            8'h01: r.step = STEP_DOWN;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spi_link_sync.sv
// Link synchroniser: brings select, clock and data into the system clock
// domain and flags serial clock edges. Assumes each serial half-period
// spans several system cycles.
module spi_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_in,
    input  logic sck_in,
    input  logic sdi_in,
    output logic csn_s,
    output logic sdi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] csn_pipe, sck_pipe, sdi_pipe;
    logic              sck_last;

    // Shift the raw pins through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_pipe <= '1;
            sck_pipe <= '0;
            sdi_pipe <= '0;
            sck_last <= 1'b0;
        end else begin
            csn_pipe <= {csn_pipe[STAGES-2:0], csn_in};
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
            sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_in};
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    assign csn_s    = csn_pipe[STAGES-1];
    assign sdi_s    = sdi_pipe[STAGES-1];
    assign sck_rise = sck_pipe[STAGES-1] & ~sck_last;
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_last;
endmodule

// File: rtl/spi_xfer_engine.sv
// Transfer engine: frames command, index and data words, steps the index
// between words, issues complete-word writes and shifts out read data.
// Assumes the bank read port is combinational on rd_idx.
module spi_xfer_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    output logic [ADDR_W-1:0] rd_idx,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_word,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int BIT_W = $clog2(DATA_W);

    phase_e            ph_q;
    step_e             step_q;
    logic              rd_q, load_q, oe_q, sdo_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-2:0] sh_q;
    logic [DATA_W-1:0] tx_q;
    logic [ADDR_W-1:0] idx_q, idx_next;
    logic [CMD_W-1:0]  byte_in;
    cmd_t              cmd_d;

    assign byte_in = {sh_q[CMD_W-2:0], sdi_s};
    assign cmd_d   = decode_cmd(byte_in);

    // Next index after a word boundary, wrapping at both ends.
    always_comb begin
        case (step_q)
            STEP_UP:   idx_next = idx_q + 1'b1;
            STEP_DOWN: idx_next = idx_q - 1'b1;
            default:   idx_next = idx_q;
        endcase
    end

    // Transaction sequencer: phases, shifting, commits and prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_CMD;  step_q <= STEP_HOLD; rd_q <= 1'b0;
            load_q <= 1'b0;  oe_q <= 1'b0;        sdo_q <= 1'b0;
            bit_q <= '0;     sh_q <= '0;          tx_q <= '0;
            idx_q <= '0;     wr_en <= 1'b0;       wr_idx <= '0;
            wr_word <= '0;
        end else if (csn_s) begin
            ph_q <= PH_CMD;  bit_q <= '0; load_q <= 1'b0;
            oe_q <= 1'b0;    wr_en <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            load_q <= 1'b0;
            if (load_q)
                tx_q <= rd_word;
            if (sck_rise) begin
                sh_q  <= {sh_q[DATA_W-3:0], sdi_s};
                bit_q <= bit_q + 1'b1;
                case (ph_q)
                    PH_CMD: if (bit_q == BIT_W'(CMD_W-1)) begin
                        bit_q  <= '0;
                        ph_q   <= cmd_d.valid ? PH_IDX : PH_SKIP;
                        rd_q   <= cmd_d.rd;
                        step_q <= cmd_d.step;
                    end
                    PH_IDX: if (bit_q == BIT_W'(ADDR_W-1)) begin
                        bit_q  <= '0;
                        ph_q   <= PH_DATA;
                        idx_q  <= byte_in;
                        load_q <= rd_q;
                        oe_q   <= rd_q;
                    end
                    PH_DATA: if (bit_q == BIT_W'(DATA_W-1)) begin
                        bit_q   <= '0;
                        idx_q   <= idx_next;
                        load_q  <= rd_q;
                        wr_en   <= ~rd_q;
                        wr_idx  <= idx_q;
                        wr_word <= {sh_q, sdi_s};
                    end
                    default: bit_q <= '0;
                endcase
            end
            if (sck_fall && ph_q == PH_DATA && rd_q) begin
                sdo_q <= tx_q[DATA_W-1];
                tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rd_idx = idx_q;
    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;

    // R7: deselect turns the driver off on the following cycle.
    p_oe_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !oe_q);
    // R7: a write transaction never enables the driver.
    p_oe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DATA && !rd_q) |-> !oe_q);
    // R12: an unknown command neither drives nor writes.
    p_skip_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SKIP) |-> (!oe_q && !wr_en));
    // R5: a fixed burst keeps its index across the data phase.
    p_hold_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DATA && step_q == STEP_HOLD && $past(ph_q == PH_DATA)) |-> $stable(idx_q));
    // R6: commits only come from a selected transaction.
    p_commit_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!csn_s));
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank: pattern word, ready status after an init delay, and a
// window of scratch registers. Read port is combinational; writes land
// on the cycle wr_en is high. Assumes the window fits in the index range.
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int                INIT_CYCLES = 1000,
    parameter int                NUM_SCR     = 4,
    parameter logic [ADDR_W-1:0] SCR_BASE    = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    localparam int                CNT_W      = $clog2(INIT_CYCLES + 1);
    localparam logic [ADDR_W-1:0] IDX_PATTERN = 8'h00;
    localparam logic [ADDR_W-1:0] IDX_STATUS  = 8'h01;

    logic [CNT_W-1:0]  init_cnt;
    logic              ready_q;
    logic [DATA_W-1:0] scr_q [NUM_SCR];

    // Count out the initialisation delay after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt <= '0;
            ready_q  <= 1'b0;
        end else if (!ready_q) begin
            init_cnt <= init_cnt + 1'b1;
            ready_q  <= (init_cnt == CNT_W'(INIT_CYCLES - 1));
        end
    end

    for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
        localparam logic [ADDR_W-1:0] MY_IDX = SCR_BASE + ADDR_W'(i);
        // Scratch register i: loads a complete word addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                scr_q[i] <= '0;
            else if (wr_en && wr_idx == MY_IDX)
                scr_q[i] <= wr_word;
        end
        // R11: untouched scratch registers keep their value.
        p_scr_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == MY_IDX) |=> $stable(scr_q[i]));
    end

    // Read multiplexer over the fixed words and the scratch window.
    always_comb begin
        rd_word = '0;
        if (rd_idx == IDX_PATTERN)
            rd_word = PATTERN_WORD;
        else if (rd_idx == IDX_STATUS)
            rd_word = {{(DATA_W-1){1'b0}}, ready_q};
        for (int k = 0; k < NUM_SCR; k++)
            if (rd_idx == SCR_BASE + ADDR_W'(k))
                rd_word = scr_q[k];
    end

    // R10: ready never drops once set while out of reset.
    p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready_q) |-> ready_q);
endmodule

// File: rtl/spi_reg_port.sv
// Top: serial register access port. Joins the link synchroniser, the
// transfer engine and the register bank. Assumes serial half-periods of
// at least four system cycles.
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int                INIT_CYCLES = 1000,
    parameter int                NUM_SCR     = 4,
    parameter logic [ADDR_W-1:0] SCR_BASE    = 8'hFC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic              csn_s, sdi_s, sck_rise, sck_fall, wr_en;
    logic [ADDR_W-1:0] rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_word, wr_word;

    spi_link_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .csn_in(spi_csn), .sck_in(spi_sck),
        .sdi_in(spi_mosi), .csn_s(csn_s), .sdi_s(sdi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    spi_xfer_engine u_eng (
        .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sdi_s(sdi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_idx(rd_idx),
        .rd_word(rd_word), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .sdo(spi_miso), .sdo_oe(spi_miso_oe)
    );

    spi_reg_bank #(
        .INIT_CYCLES(INIT_CYCLES), .NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    // R8: the driver is off on the first cycle after reset release.
    p_rst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !spi_miso_oe);
endmodule

// File: tb/spi_reg_port_tb.sv
// Directed bench for spi_reg_port: one task per scenario, each checking
// its own results at the serial pins.
module spi_reg_port_tb_top;
    localparam int HP = 8;
    localparam logic [31:0] PAT = 32'h1A2B_3C4D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;

    int n_chk = 0, n_bad = 0;
    logic oe_seen;
    logic [31:0] rbuf [4];
    logic [31:0] W_A = 32'h1357_9BDF, W_B = 32'h2468_ACE0;

    always #2 clk = ~clk;

    spi_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel();
        @(negedge clk); csn = 1'b0; oe_seen = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HP) @(negedge clk); csn = 1'b1;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        mosi = b;
        repeat (HP) @(negedge clk);
        r = miso;
        if (miso_oe) oe_seen = 1'b1;
        sck = 1'b1;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xbits(input logic [31:0] v, input int n, output logic [31:0] r);
        logic b;
        r = '0;
        for (int i = n-1; i >= 0; i--) begin
            xbit(v[i], b);
            r = {r[30:0], b};
        end
    endtask

    // Read burst of n words into rbuf; checks the header phases are quiet (R7).
    task automatic rd_burst(input logic [7:0] cmd, input logic [7:0] idx, input int n, input string tag);
        logic [31:0] r;
        sel();
        xbits({24'h0, cmd}, 8, r);
        xbits({24'h0, idx}, 8, r);
        chk({tag, " R7 header quiet"}, {31'h0, oe_seen}, 32'h0);
        for (int w = 0; w < n; w++) begin
            xbits(32'h0, 32, r);
            rbuf[w] = r;
        end
        desel();
    endtask

    // Write burst; the last word may be cut to last_bits; checks R7 quiet.
    task automatic wr_burst(input logic [7:0] cmd, input logic [7:0] idx,
                            input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input int n, input int last_bits,
                            input string tag);
        logic [31:0] r;
        logic [31:0] ws [3];
        ws[0] = w0; ws[1] = w1; ws[2] = w2;
        sel();
        xbits({24'h0, cmd}, 8, r);
        xbits({24'h0, idx}, 8, r);
        for (int w = 0; w < n; w++)
            xbits(ws[w] >> ((w == n-1) ? (32 - last_bits) : 0), (w == n-1) ? last_bits : 32, r);
        desel();
        chk({tag, " R7 write quiet"}, {31'h0, oe_seen}, 32'h0);
    endtask

    task automatic t_reset_quiet();
        chk("R8 oe in reset", {31'h0, miso_oe}, 32'h0);
        rd_burst(8'h0A, 8'h00, 1, "reset");
        chk("R8 no drive during reset", {31'h0, oe_seen}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_poll_ready();
        rd_burst(8'h0B, 8'h00, 2, "poll");
        chk("R9 R1 pattern word", rbuf[0], PAT);
        chk("R10 not ready yet", rbuf[1], 32'h0);
    endtask

    task automatic t_up_wrap();
        wr_burst(8'h02, 8'hFE, W_A, W_B, 32'hF0E1_D2C3, 3, 32, "up");
        rd_burst(8'h0B, 8'hFF, 2, "up");
        chk("R3 R2 word at FF", rbuf[0], W_B);
        chk("R3 wrap to 00 and R9 write ignored", rbuf[1], PAT);
    endtask

    task automatic t_down_wrap();
        rd_burst(8'h09, 8'h00, 3, "down");
        chk("R4 first word 00", rbuf[0], PAT);
        chk("R4 wrap to FF", rbuf[1], W_B);
        chk("R4 then FE", rbuf[2], W_A);
    endtask

    task automatic t_fixed();
        wr_burst(8'h03, 8'hFC, 32'hCAFE_0001, 32'h0BAD_F00D, 32'h0, 2, 32, "fixed");
        rd_burst(8'h0A, 8'hFC, 2, "fixed");
        chk("R5 last word wins", rbuf[0], 32'h0BAD_F00D);
        chk("R5 fixed repeat", rbuf[1], 32'h0BAD_F00D);
        rd_burst(8'h0A, 8'hFD, 1, "fixed");
        chk("R5 neighbour untouched", rbuf[0], 32'h0);
    endtask

    task automatic t_partial();
        wr_burst(8'h02, 8'hFD, 32'h5A5A_A5A5, 32'hFFFF_FFFF, 32'h0, 2, 20, "partial");
        rd_burst(8'h0B, 8'hFD, 2, "partial");
        chk("R6 full word kept", rbuf[0], 32'h5A5A_A5A5);
        chk("R6 partial dropped", rbuf[1], W_A);
        wr_burst(8'h03, 8'hFC, 32'h1111_2222, 32'h0, 32'h0, 1, 12, "partial");
        rd_burst(8'h0A, 8'hFC, 1, "partial");
        chk("R6 lone partial dropped", rbuf[0], 32'h0BAD_F00D);
    endtask

    task automatic t_bad_cmd();
        logic [31:0] r;
        sel();
        xbits(32'h55, 8, r);
        xbits(32'hFC, 8, r);
        xbits(32'hFFFF_FFFF, 32, r);
        xbits(32'hFFFF_FFFF, 32, r);
        desel();
        chk("R12 no drive on unknown code", {31'h0, oe_seen}, 32'h0);
        rd_burst(8'h0A, 8'hFC, 1, "badcmd");
        chk("R12 no write on unknown code", rbuf[0], 32'h0BAD_F00D);
    endtask

    task automatic t_down_write();
        wr_burst(8'h01, 8'hFF, 32'h0F0F_1234, 32'h7777_8888, 32'h0, 2, 32, "dnwr");
        rd_burst(8'h09, 8'hFF, 2, "dnwr");
        chk("R4 write-down FF", rbuf[0], 32'h0F0F_1234);
        chk("R4 write-down FE", rbuf[1], 32'h7777_8888);
    endtask

    task automatic t_read_only();
        wr_burst(8'h02, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2, 32, "ro");
        rd_burst(8'h0B, 8'h00, 2, "ro");
        chk("R9 pattern read-only", rbuf[0], PAT);
        chk("R10 ready set and read-only", rbuf[1], 32'h1);
        wr_burst(8'h03, 8'h40, 32'hDEAD_BEEF, 32'h0, 32'h0, 1, 32, "ro");
        rd_burst(8'h0A, 8'h40, 1, "ro");
        chk("R11 unmapped reads zero", rbuf[0], 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (10) @(negedge clk);
        t_reset_quiet();
        t_poll_ready();
        t_up_wrap();
        t_down_wrap();
        t_fixed();
        t_partial();
        t_bad_cmd();
        t_down_write();
        t_read_only();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule